// File: doc/BRIEF.md
# Low-Power Clock-Stop Sequencer

This block is glue logic that sits between the system clock and a static processor core. It lets software park the core in a stopped-clock state and later revive it. Software first performs a supervisor data write to a chosen trigger address. The sequencer watches the address strobe from that write onward. When the stop instruction's immediate operand has been fetched, it removes the processor clock on a falling edge of the system clock. The clock comes back when an external restart input is raised.

The number of strobe cycles that must complete before the stop depends on the data-bus width. A 16-bit bus needs two bus cycles after the trigger write. An 8-bit bus needs three, because it fetches the immediate operand in two bus cycles. The gated clock is the system clock AND-ed with an enable held in a latch. That latch is transparent only while the system clock is low, so the output never carries a shortened high pulse.

The controller has four named states:
- ST_IDLE: the clock runs and the decoder watches for the trigger.
- ST_ARMED: the trigger write is in progress.
- ST_COUNT: completed strobe cycles are being counted.
- ST_STOPPED: the clock is gated off.

It has four named transitions:
- *hit*: ST_IDLE to ST_ARMED, on a decoded trigger.
- *trigger done*: ST_ARMED to ST_COUNT, when the trigger cycle completes.
- *last cycle*: ST_COUNT to ST_STOPPED, when the final cycle completes.
- *wake*: ST_STOPPED to ST_IDLE, on restart.

Top module: `lpstop_seq`

## Requirements
- R1: While `rst` is high, the block is asynchronously held in ST_IDLE and `cpu_clk` follows `sys_clk` pulse for pulse. This also holds when reset is applied while the clock is stopped.
- R2: A trigger is decoded at a rising `sys_clk` edge when all of the following hold: `bus_as_n` = 0, `bus_rd_wr_n` = 0 (write), `bus_fc` = 3'b101 (supervisor data) and `bus_addr` equals the parameter TRIGGER_ADDR.
- R3: An access that fails any one trigger condition leaves the sequencer idle. Examples are a read, function code 3'b001 or 3'b110, or a different address. The clock then keeps running through any number of later bus cycles.
- R4: With `narrow_bus` = 0, the clock stops after the second bus cycle that completes after the trigger cycle. A cycle completes at a rising edge that samples `bus_as_n` high when the previous rising edge sampled it low.
- R5: With `narrow_bus` = 1, the clock stops after the third bus cycle that completes after the trigger cycle.
- R6: The last `cpu_clk` high pulse is the one at the rising edge that sees the final cycle complete. No later pulse appears until a restart or reset. With L strobe-low and H strobe-high edges per cycle, exactly N*(L+H)+L+1 pulses occur from the trigger cycle's first edge, where N is 2 or 3.
- R7: `restart` sampled high at a rising edge in ST_STOPPED re-enables the clock from the next falling edge. That edge's own pulse is absent, and every later edge produces a pulse.
- R8: `cpu_clk` rises only together with `sys_clk`, and every high pulse lasts a full high phase of `sys_clk`, across stops and restarts.
- R9: `restart` has no effect outside ST_STOPPED. The stop point of a sequence in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Free-running system clock |
| rst | input | 1 | Asynchronous reset, active high |
| bus_addr | input | ADDR_W | Processor address bus |
| bus_rd_wr_n | input | 1 | 1 = read, 0 = write |
| bus_fc | input | 3 | Processor function code |
| bus_as_n | input | 1 | Address strobe, active low |
| restart | input | 1 | Wake request, active high |
| narrow_bus | input | 1 | 1 = 8-bit data bus, 0 = 16-bit |
| cpu_clk | output | 1 | Gated processor clock |

## Verification
Full stop-and-wake sequences are swept over both bus widths, three strobe-low lengths and two strobe-high lengths. The pulse count from the trigger is compared with the arithmetic expectation. This separates an off-by-one in either mode and a miscounted cycle boundary. Single-field violations of the trigger tell apart which decode term is missing. Restart pulses during counting reveal whether wake is guarded by state. Pulse-width and edge-alignment monitors, together with counts taken right after restart and under reset, expose runt pulses and a misplaced enable latch.

// File: rtl/lpstop_pkg.sv
package lpstop_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ARMED   = 2'd1,
        ST_COUNT   = 2'd2,
        ST_STOPPED = 2'd3
    } seq_state_t;

    // Function code marking a supervisor data access
    localparam logic [2:0] FC_SUP_DATA = 3'b101;

endpackage

// File: rtl/lpstop_match.sv
module lpstop_match #(
    parameter int            ADDR_W       = 24,
    parameter logic [ADDR_W-1:0] TRIGGER_ADDR = '0
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd_wr_n,
    input  logic [2:0]        bus_fc,
    input  logic              bus_as_n,
    output logic              trig_hit
);
    import lpstop_pkg::*;

    logic addr_eq;
    logic fc_ok;
    logic is_write;
    logic strobe;

    always_comb begin
        addr_eq  = (bus_addr == TRIGGER_ADDR);
        fc_ok    = (bus_fc == FC_SUP_DATA);
        is_write = ~bus_rd_wr_n;
        strobe   = ~bus_as_n;
        trig_hit = addr_eq & fc_ok & is_write & strobe;
    end

endmodule

// File: rtl/lpstop_fsm.sv
module lpstop_fsm #(
    parameter int CYC_WIDE   = 2,
    parameter int CYC_NARROW = 3,
    parameter int CNT_W      = 2
) (
    input  logic                   sys_clk,
    input  logic                   rst,
    input  logic                   trig_hit,
    input  logic                   bus_as_n,
    input  logic                   restart,
    input  logic                   narrow_bus,
    output lpstop_pkg::seq_state_t state,
    output logic [CNT_W-1:0]       cyc_cnt,
    output logic                   run_en
);
    import lpstop_pkg::*;

    localparam logic [CNT_W-1:0] LAST_WIDE   = CNT_W'(CYC_WIDE - 1);
    localparam logic [CNT_W-1:0] LAST_NARROW = CNT_W'(CYC_NARROW - 1);

    seq_state_t       nxt;
    logic             as_low_q;
    logic             cyc_end;
    logic             cnt_clr;
    logic             cnt_inc;
    logic [CNT_W-1:0] last_idx;

    // Strobe history for cycle-completion detection
    always_ff @(posedge sys_clk or posedge rst) begin
        if (rst) as_low_q <= 1'b0;
        else     as_low_q <= ~bus_as_n;
    end

    always_comb begin
        cyc_end  = as_low_q & bus_as_n;
        last_idx = narrow_bus ? LAST_NARROW : LAST_WIDE;
    end

    // State register and cycle counter
    always_ff @(posedge sys_clk or posedge rst) begin
        if (rst) begin
            state   <= ST_IDLE;
            cyc_cnt <= '0;
        end else begin
            state <= nxt;
            if (cnt_clr)      cyc_cnt <= '0;
            else if (cnt_inc) cyc_cnt <= cyc_cnt + 1'b1;
        end
    end

    // Transitions
    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (trig_hit) nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (cyc_end) begin
                    nxt     = ST_COUNT;
                    cnt_clr = 1'b1;
                end
            end
            ST_COUNT: begin
                if (cyc_end) begin
                    if (cyc_cnt >= last_idx) nxt = ST_STOPPED;
                    else                     cnt_inc = 1'b1;
                end
            end
            ST_STOPPED: begin
                if (restart) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state)
            ST_STOPPED: run_en = 1'b0;
            default:    run_en = 1'b1;
        endcase
    end

endmodule

// File: rtl/lpstop_clkgate.sv
module lpstop_clkgate (
    input  logic sys_clk,
    input  logic rst,
    input  logic run_en,
    output logic gate_en,
    output logic cpu_clk
);
    // Enable changes only in the low phase, so the AND never clips a pulse
    always_latch begin
        if (rst)           gate_en = 1'b1;
        else if (!sys_clk) gate_en = run_en;
    end

    assign cpu_clk = sys_clk & gate_en;

endmodule

// File: rtl/lpstop_seq.sv
module lpstop_seq #(
    parameter int                ADDR_W       = 24,
    parameter logic [ADDR_W-1:0] TRIGGER_ADDR = 24'hFF_F000,
    parameter int                CYC_WIDE     = 2,
    parameter int                CYC_NARROW   = 3
) (
    input  logic              sys_clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd_wr_n,
    input  logic [2:0]        bus_fc,
    input  logic              bus_as_n,
    input  logic              restart,
    input  logic              narrow_bus,
    output logic              cpu_clk
);
    import lpstop_pkg::*;

    localparam int MAX_CYC = (CYC_NARROW > CYC_WIDE) ? CYC_NARROW : CYC_WIDE;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic             trig_hit;
    seq_state_t       state;
    logic [CNT_W-1:0] cyc_cnt;
    logic             run_en;
    logic             gate_en;

    lpstop_match #(
        .ADDR_W      (ADDR_W),
        .TRIGGER_ADDR(TRIGGER_ADDR)
    ) u_match (
        .bus_addr   (bus_addr),
        .bus_rd_wr_n(bus_rd_wr_n),
        .bus_fc     (bus_fc),
        .bus_as_n   (bus_as_n),
        .trig_hit   (trig_hit)
    );

    lpstop_fsm #(
        .CYC_WIDE  (CYC_WIDE),
        .CYC_NARROW(CYC_NARROW),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .sys_clk   (sys_clk),
        .rst       (rst),
        .trig_hit  (trig_hit),
        .bus_as_n  (bus_as_n),
        .restart   (restart),
        .narrow_bus(narrow_bus),
        .state     (state),
        .cyc_cnt   (cyc_cnt),
        .run_en    (run_en)
    );

    lpstop_clkgate u_gate (
        .sys_clk(sys_clk),
        .rst    (rst),
        .run_en (run_en),
        .gate_en(gate_en),
        .cpu_clk(cpu_clk)
    );

endmodule

// File: rtl/lpstop_seq_chk.sv
module lpstop_seq_chk #(
    parameter int CYC_WIDE   = 2,
    parameter int CYC_NARROW = 3,
    parameter int CNT_W      = 2
) (
    input logic                   sys_clk,
    input logic                   rst,
    input logic                   restart,
    input logic                   narrow_bus,
    input logic                   trig_hit,
    input lpstop_pkg::seq_state_t state,
    input logic [CNT_W-1:0]       cyc_cnt,
    input logic                   gate_en,
    input logic                   cpu_clk
);
    import lpstop_pkg::*;

    // R2
    arm_on_hit_chk: assert property (@(posedge sys_clk) disable iff (rst)
        (state == ST_IDLE && trig_hit) |=> (state == ST_ARMED));

    // R3
    idle_hold_chk: assert property (@(posedge sys_clk) disable iff (rst)
        (state == ST_IDLE && !trig_hit) |=> (state == ST_IDLE));

    // R5
    cnt_bound_chk: assert property (@(posedge sys_clk) disable iff (rst)
        (state == ST_COUNT) |-> (cyc_cnt < CNT_W'(narrow_bus ? CYC_NARROW : CYC_WIDE)));

    // R6
    gate_off_chk: assert property (@(posedge sys_clk) disable iff (rst)
        (state == ST_STOPPED) |-> !gate_en);

    // R6
    gate_on_chk: assert property (@(posedge sys_clk) disable iff (rst)
        (state != ST_STOPPED) |-> gate_en);

    // R7
    wake_chk: assert property (@(posedge sys_clk) disable iff (rst)
        (state == ST_STOPPED && restart) |=> (state == ST_IDLE));

    // R9
    count_keep_chk: assert property (@(posedge sys_clk) disable iff (rst)
        (state == ST_COUNT) |=> (state == ST_COUNT || state == ST_STOPPED));

    // R8
    always @(posedge cpu_clk) begin
        rise_aligned_chk: assert (sys_clk);
    end

endmodule

bind lpstop_seq lpstop_seq_chk #(
    .CYC_WIDE  (CYC_WIDE),
    .CYC_NARROW(CYC_NARROW),
    .CNT_W     (CNT_W)
) u_chk (
    .sys_clk   (sys_clk),
    .rst       (rst),
    .restart   (restart),
    .narrow_bus(narrow_bus),
    .trig_hit  (trig_hit),
    .state     (state),
    .cyc_cnt   (cyc_cnt),
    .gate_en   (gate_en),
    .cpu_clk   (cpu_clk)
);

// File: tb/test_lpstop_seq.sv
module test_lpstop_seq;

    localparam int          ADDR_W = 24;
    localparam logic [23:0] TADDR  = 24'hFF_F000;
    localparam realtime     HALF   = 10ns;

    bit          sys_clk = 1'b0;
    logic        rst;
    logic [23:0] bus_addr;
    logic        bus_rd_wr_n;
    logic [2:0]  bus_fc;
    logic        bus_as_n;
    logic        restart;
    logic        narrow_bus;
    logic        cpu_clk;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int glitches = 0;
    bit seen_rise = 1'b0;
    bit done = 1'b0;
    realtime t_rise = 0;

    always #(HALF) sys_clk = ~sys_clk;

    lpstop_seq #(.ADDR_W(ADDR_W), .TRIGGER_ADDR(TADDR)) i_lpstop_seq (
        .sys_clk(sys_clk), .rst(rst), .bus_addr(bus_addr),
        .bus_rd_wr_n(bus_rd_wr_n), .bus_fc(bus_fc), .bus_as_n(bus_as_n),
        .restart(restart), .narrow_bus(narrow_bus), .cpu_clk(cpu_clk)
    );

    // Pulse counter and runt monitor (R8)
    always @(posedge cpu_clk) begin
        pulses++;
        t_rise = $realtime;
        seen_rise = 1'b1;
        if (!sys_clk) glitches++;
    end
    always @(negedge cpu_clk) begin
        if (seen_rise && ($realtime - t_rise != HALF)) glitches++;
    end

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        bus_as_n = 1'b1; bus_rd_wr_n = 1'b1; bus_fc = 3'b110; bus_addr = 24'h000400;
    endtask

    // Called just after a falling edge; returns just after a falling edge
    task automatic bus_cycle(logic [23:0] a, logic rw, logic [2:0] f,
                             int lo, int hi, bit rs);
        bus_addr = a; bus_rd_wr_n = rw; bus_fc = f; bus_as_n = 1'b0;
        restart = rs;
        @(negedge sys_clk);
        restart = 1'b0;
        repeat (lo - 1) @(negedge sys_clk);
        idle_bus();
        repeat (hi) @(negedge sys_clk);
    endtask

    task automatic run_seq(bit nb, int lo, int hi, bit rs_mid);
        int n;
        int base;
        n = nb ? 3 : 2;
        narrow_bus = nb;
        base = pulses;
        bus_cycle(TADDR, 1'b0, 3'b101, lo, hi, rs_mid);
        for (int i = 0; i < n; i++) bus_cycle(24'h001000 + 24'(i), 1'b1, 3'b110, lo, hi, rs_mid);
        repeat (4) @(negedge sys_clk);
        if (rs_mid)
            check("R9 restart ignored while counting", pulses - base, n * (lo + hi) + lo + 1);
        else if (nb)
            check("R5 narrow stop count", pulses - base, n * (lo + hi) + lo + 1);
        else
            check("R4 wide stop count", pulses - base, n * (lo + hi) + lo + 1);
        base = pulses;
        repeat (5) @(negedge sys_clk);
        check("R6 no pulse while stopped", pulses - base, 0);
        base = pulses;
        restart = 1'b1;
        @(negedge sys_clk);
        restart = 1'b0;
        check("R7 no pulse at restart edge", pulses - base, 0);
        repeat (4) @(negedge sys_clk);
        check("R7 pulses after restart", pulses - base, 4);
        check("R8 no runt or misaligned pulse", glitches, 0);
    endtask

    task automatic no_trigger(string what, logic [23:0] a, logic rw, logic [2:0] f);
        int base;
        narrow_bus = 1'b0;
        base = pulses;
        bus_cycle(a, rw, f, 2, 1, 1'b0);
        for (int i = 0; i < 3; i++) bus_cycle(24'h002000, 1'b1, 3'b110, 2, 1, 1'b0);
        repeat (4) @(negedge sys_clk);
        check({"R3 ignored ", what}, pulses - base, 16);
    endtask

    initial begin
        int base;
        rst = 1'b1; restart = 1'b0; narrow_bus = 1'b0;
        idle_bus();
        @(negedge sys_clk);
        base = pulses;
        repeat (4) @(negedge sys_clk);
        check("R1 clock runs in reset", pulses - base, 4);
        rst = 1'b0;
        repeat (2) @(negedge sys_clk);

        // Single-field violations of the trigger (R2 decode, R3 ignored)
        no_trigger("read", TADDR, 1'b1, 3'b101);
        no_trigger("user data fc", TADDR, 1'b0, 3'b001);
        no_trigger("supervisor program fc", TADDR, 1'b0, 3'b110);
        no_trigger("low address bit", TADDR ^ 24'h000001, 1'b0, 3'b101);
        no_trigger("high address bit", TADDR ^ 24'h800000, 1'b0, 3'b101);

        // Sweep both widths and strobe shapes (R2, R4, R5, R6, R7, R8)
        for (int nb = 0; nb < 2; nb++)
            for (int lo = 1; lo <= 3; lo++)
                for (int hi = 1; hi <= 2; hi++)
                    run_seq(nb[0], lo, hi, 1'b0);

        // Restart pulses during the sequence (R9)
        run_seq(1'b0, 2, 1, 1'b1);
        run_seq(1'b1, 1, 2, 1'b1);

        // Reset while stopped (R1)
        narrow_bus = 1'b0;
        bus_cycle(TADDR, 1'b0, 3'b101, 1, 1, 1'b0);
        bus_cycle(24'h003000, 1'b1, 3'b110, 1, 1, 1'b0);
        bus_cycle(24'h003002, 1'b1, 3'b110, 1, 1, 1'b0);
        repeat (2) @(negedge sys_clk);
        base = pulses;
        repeat (2) @(negedge sys_clk);
        check("R6 stopped before reset", pulses - base, 0);
        rst = 1'b1;
        base = pulses;
        repeat (3) @(negedge sys_clk);
        check("R1 reset revives clock", pulses - base, 3);
        rst = 1'b0;
        @(negedge sys_clk);
        run_seq(1'b1, 2, 2, 1'b0);
        check("R8 final runt check", glitches, 0);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20ns * 100000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule